// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Masked Output Writes and Shared Interrupt

This block is a 16-pin general-purpose I/O port on a simple word-addressed register bus. Each pin has a direction bit and an output value. Software changes any subset of the output values in one write, because the upper half of the write word is a per-pin mask. A pin-state register returns the pin levels after a two-stage synchronizer.

The synchronized levels of pins 0 to 7 each drive their own active-high interrupt request. Pins 8 to 15 are each gated by an interrupt-enable bit, and the gated levels are ORed into one shared active-high request. All requests follow the pin levels directly, with no latching. An external interrupt controller consumes the requests.

A control register holds two bits: a clock enable and a block reset. Writing 3 and then 1 resets the port and then starts it. Writing 2 parks the port in reset with its clock off, which is the low-power state. When the clock enable is 0, the port holds its state.

Top module: `gpio16_port`

## Requirements
- R1: After hard reset (`rst_n` low), the control register reads 2 (reset held, clock off). `pin_oe`, `pin_out`, `irq_each` and `irq_shared` are all 0.
- R2: A write to the output register (word address 1) with the clock enabled and the reset bit clear updates `pin_out[i]` to `wdata[i]` only where `wdata[16+i]` is 1. Every other output bit keeps its value.
- R3: The direction register (word address 0) drives `pin_oe`, where 1 means output and 0 means input. It is written whole and reads back in bits 15:0.
- R4: A read of the pin-state register (word address 2) returns the synchronized pin levels in bits 15:0 and zero above. A pin change is visible two clock edges after it is applied.
- R5: `irq_each[i]`, for pins 0 to 7, equals the synchronized level of pin i. It is active high and level-sensitive.
- R6: `irq_shared` is the OR, over pins 8 to 15, of the synchronized pin level ANDed with interrupt-enable bit i (word address 3, bits 15:8).
- R7: The control register is at word address 4, with bit 0 as clock enable and bit 1 as reset. Writes to it are always accepted. Writing 3 and then 1 leaves the port reset and then in normal operation.
- R8: While the reset bit is 1, the direction, output and interrupt-enable registers and the synchronizer are held at zero, and writes to those registers are ignored.
- R9: While the clock enable is 0, writes to the direction, output and interrupt-enable registers are ignored. Pin sampling is frozen, so the pin-state register and the interrupt requests hold their values.
- R10: The output register reads back the current output values in bits 15:0 with bits 31:16 zero. The interrupt-enable register reads back only bits 15:8.
- R11: Read data appears on `bus_rdata` one cycle after the read request and is zero in every other cycle. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Output values |
| pin_oe | output | 16 | Output enables (1 = drive) |
| irq_each | output | 8 | Dedicated requests for pins 0 to 7 |
| irq_shared | output | 1 | Combined request for pins 8 to 15 |

## Verification
Register writes show on `pin_out` and `pin_oe` after the single clock edge that accepts them. Read data is due on the edge after the request. A pin change reaches the pin-state register, `irq_each` and `irq_shared` only after two edges.

A behavioural model in the bench advances on the same edges and is compared at each falling edge, so every output is checked at the cycle it is due. The directed checks wait at least three cycles after a pin change before they sample.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DIR  = 3'd0,
        ADDR_OUT  = 3'd1,
        ADDR_PINS = 3'd2,
        ADDR_IEN  = 3'd3,
        ADDR_CTRL = 3'd4
    } reg_addr_e;

    localparam int unsigned CTRL_CLKEN = 0;
    localparam int unsigned CTRL_RST   = 1;
    localparam logic [1:0]  CTRL_POR   = 2'b10;
endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (clr) begin
            stg_d = '0;
        end else if (en) begin
            stg_d[0] = d;
            for (int i = 1; i < STAGES; i++) begin
                stg_d[i] = stg_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];

    // R9
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(q));
endmodule

// File: rtl/gpio16_irq.sv
module gpio16_irq #(
    parameter int unsigned NUM_PINS     = 16,
    parameter int unsigned SHARED_FIRST = 8
) (
    input  logic [NUM_PINS-1:0]     lvl,
    input  logic [NUM_PINS-1:0]     ien,
    output logic [SHARED_FIRST-1:0] irq_each,
    output logic                    irq_shared
);
    localparam int unsigned SHARED_N = NUM_PINS - SHARED_FIRST;

    logic [SHARED_N-1:0] gated;

    for (genvar i = 0; i < SHARED_FIRST; i++) begin : g_each
        assign irq_each[i] = lvl[i];
    end

    for (genvar j = 0; j < SHARED_N; j++) begin : g_shared
        assign gated[j] = lvl[SHARED_FIRST+j] & ien[SHARED_FIRST+j];
    end

    assign irq_shared = |gated;

    always_comb begin
        // R6
        if (ien[NUM_PINS-1:SHARED_FIRST] == '0) begin
            no_enable_quiet_chk: assert (!irq_shared);
        end
    end
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
    import gpio16_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 16,
    parameter int unsigned SHARED_FIRST = 8,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [2*NUM_PINS-1:0]   bus_wdata,
    output logic [2*NUM_PINS-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0]     pin_in,
    output logic [NUM_PINS-1:0]     pin_out,
    output logic [NUM_PINS-1:0]     pin_oe,
    output logic [SHARED_FIRST-1:0] irq_each,
    output logic                    irq_shared
);
    localparam int unsigned BUS_W    = 2 * NUM_PINS;
    localparam int unsigned SHARED_N = NUM_PINS - SHARED_FIRST;
    localparam logic [NUM_PINS-1:0] IEN_MASK = {{SHARED_N{1'b1}}, {SHARED_FIRST{1'b0}}};

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] ien;
        logic [1:0]          ctrl;
        logic [BUS_W-1:0]    rdata;
    } port_state_t;

    port_state_t         st_d, st_q;
    logic [NUM_PINS-1:0] lvl;
    logic                wr_hit, rd_hit;
    logic [NUM_PINS-1:0] wmask, wval;
    reg_addr_e           addr;

    assign wr_hit = bus_sel & bus_wr;
    assign rd_hit = bus_sel & ~bus_wr;
    assign wmask  = bus_wdata[BUS_W-1:NUM_PINS];
    assign wval   = bus_wdata[NUM_PINS-1:0];
    assign addr   = reg_addr_e'(bus_addr);

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_hit && addr == ADDR_CTRL) begin
            st_d.ctrl = bus_wdata[1:0];
        end
        if (rd_hit) begin
            case (addr)
                ADDR_DIR:  st_d.rdata = {{NUM_PINS{1'b0}}, st_q.dir};
                ADDR_OUT:  st_d.rdata = {{NUM_PINS{1'b0}}, st_q.out};
                ADDR_PINS: st_d.rdata = {{NUM_PINS{1'b0}}, lvl};
                ADDR_IEN:  st_d.rdata = {{NUM_PINS{1'b0}}, st_q.ien};
                ADDR_CTRL: st_d.rdata = {{(BUS_W-2){1'b0}}, st_q.ctrl};
                default:   st_d.rdata = '0;
            endcase
        end
        if (st_d.ctrl[CTRL_RST]) begin
            st_d.dir = '0;
            st_d.out = '0;
            st_d.ien = '0;
        end else if (st_q.ctrl[CTRL_CLKEN] && wr_hit) begin
            case (addr)
                ADDR_DIR: st_d.dir = wval;
                ADDR_OUT: st_d.out = (st_q.out & ~wmask) | (wval & wmask);
                ADDR_IEN: st_d.ien = wval & IEN_MASK;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_POR;
        end else begin
            st_q <= st_d;
        end
    end

    gpio16_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.ctrl[CTRL_CLKEN]),
        .clr   (st_d.ctrl[CTRL_RST]),
        .d     (pin_in),
        .q     (lvl)
    );

    gpio16_irq #(.NUM_PINS(NUM_PINS), .SHARED_FIRST(SHARED_FIRST)) u_irq (
        .lvl        (lvl),
        .ien        (st_q.ien),
        .irq_each   (irq_each),
        .irq_shared (irq_shared)
    );

    assign pin_out   = st_q.out;
    assign pin_oe    = st_q.dir;
    assign bus_rdata = st_q.rdata;

    // R8
    rst_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl[CTRL_RST] |-> (pin_oe == '0 && pin_out == '0 && st_q.ien == '0));

    // R9
    clk_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl[CTRL_CLKEN] && !(wr_hit && addr == ADDR_CTRL))
        |=> ($stable(pin_oe) && $stable(pin_out) && $stable(st_q.ien)));

    // R2
    masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && addr == ADDR_OUT && st_q.ctrl == 2'b01)
        |=> pin_out == (($past(pin_out) & ~$past(wmask)) | ($past(wval) & $past(wmask))));

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> bus_rdata == '0);
endmodule

// File: tb/gpio16_port_tb.sv
module gpio16_port_tb;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0, pin_out, pin_oe;
    logic [7:0]  irq_each;
    logic        irq_shared;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio16_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_each(irq_each), .irq_shared(irq_shared)
    );

    // behavioural reference
    logic [15:0] m_dir, m_out, m_ien, m_s1, m_s2;
    logic [1:0]  m_ctrl;
    logic [31:0] m_rd;
    bit          m_live = 0;

    always @(posedge clk) begin
        logic [1:0]  nc;
        logic [31:0] r;
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_ien = 0; m_s1 = 0; m_s2 = 0;
            m_ctrl = 2'b10; m_rd = 0; m_live = 0;
        end else begin
            nc = (bus_sel && bus_wr && bus_addr == 3'd4) ? bus_wdata[1:0] : m_ctrl;
            r = 0;
            if (bus_sel && !bus_wr) begin
                if (bus_addr == 3'd0) r = {16'h0, m_dir};
                else if (bus_addr == 3'd1) r = {16'h0, m_out};
                else if (bus_addr == 3'd2) r = {16'h0, m_s2};
                else if (bus_addr == 3'd3) r = {16'h0, m_ien};
                else if (bus_addr == 3'd4) r = {30'h0, m_ctrl};
            end
            if (nc[1]) begin
                m_dir = 0; m_out = 0; m_ien = 0; m_s1 = 0; m_s2 = 0;
            end else if (m_ctrl[0]) begin
                if (bus_sel && bus_wr) begin
                    if (bus_addr == 3'd0) m_dir = bus_wdata[15:0];
                    if (bus_addr == 3'd1)
                        for (int i = 0; i < 16; i++)
                            if (bus_wdata[16+i]) m_out[i] = bus_wdata[i];
                    if (bus_addr == 3'd3) m_ien = bus_wdata[15:0] & 16'hFF00;
                end
                m_s2 = m_s1;
                m_s1 = pin_in;
            end
            m_ctrl = nc;
            m_rd = r;
            m_live = 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            check("R2 pin_out model", {16'h0, pin_out}, {16'h0, m_out});
            check("R3 pin_oe model", {16'h0, pin_oe}, {16'h0, m_dir});
            check("R5 irq_each model", {24'h0, irq_each}, {24'h0, m_s2[7:0]});
            check("R6 irq_shared model", {31'h0, irq_shared}, {31'h0, |(m_s2 & m_ien)});
            check("R11 rdata model", bus_rdata, m_rd);
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        #1 bus_sel = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #40000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        idle(3);
        // R1 reset state
        check("R1 pin_oe", {16'h0, pin_oe}, 0);
        check("R1 pin_out", {16'h0, pin_out}, 0);
        check("R1 irqs", {23'h0, irq_shared, irq_each}, 0);
        #1 rst_n = 1;
        rd(3'd4, v); check("R1 ctrl", v, 2);
        // R7 reset then run
        wr(3'd4, 3); wr(3'd4, 1);
        rd(3'd4, v); check("R7 ctrl", v, 1);
        // R3 direction
        wr(3'd0, 32'h0000_00FF);
        rd(3'd0, v); check("R3 dir readback", v, 32'h00FF);
        check("R3 pin_oe", {16'h0, pin_oe}, 32'h00FF);
        // R2 masked output writes
        wr(3'd1, 32'h000F_00A5);
        check("R2 low nibble", {16'h0, pin_out}, 32'h0005);
        wr(3'd1, 32'h00F0_FFFF);
        check("R2 second nibble", {16'h0, pin_out}, 32'h00F5);
        // R10 out readback
        wr(3'd1, 32'hFFFF_00F5);
        rd(3'd1, v); check("R10 out readback", v, 32'h0000_00F5);
        // R4/R5 pins and dedicated irqs
        @(negedge clk); #1 pin_in = 16'h0081;
        idle(3);
        check("R5 irq_each", {24'h0, irq_each}, 32'h81);
        rd(3'd2, v); check("R4 pin state", v, 32'h0081);
        // R10/R6 interrupt enable and shared request
        wr(3'd3, 32'hFFFF_0300);
        rd(3'd3, v); check("R10 ien readback", v, 32'h0300);
        @(negedge clk); #1 pin_in = 16'h0400;
        idle(3);
        check("R6 disabled pin", {31'h0, irq_shared}, 0);
        @(negedge clk); #1 pin_in = 16'h0281;
        idle(3);
        check("R6 enabled pin", {31'h0, irq_shared}, 1);
        // R9 clock off: hold
        wr(3'd4, 0);
        wr(3'd0, 32'h0000_FFFF);
        rd(3'd0, v); check("R9 dir write ignored", v, 32'h00FF);
        @(negedge clk); #1 pin_in = 16'h0000;
        idle(3);
        check("R9 irq_each frozen", {24'h0, irq_each}, 32'h81);
        check("R9 irq_shared frozen", {31'h0, irq_shared}, 1);
        rd(3'd2, v); check("R9 pin state frozen", v, 32'h0281);
        // R8 reset held
        wr(3'd4, 2);
        check("R8 pin_oe zero", {16'h0, pin_oe}, 0);
        check("R8 pin_out zero", {16'h0, pin_out}, 0);
        wr(3'd0, 32'h0000_FFFF);
        rd(3'd0, v); check("R8 dir write ignored", v, 0);
        rd(3'd2, v); check("R8 pin state zero", v, 0);
        check("R8 irq_shared", {31'h0, irq_shared}, 0);
        // R7 restart
        wr(3'd4, 3); wr(3'd4, 1);
        wr(3'd1, 32'hFFFF_1234);
        check("R7 running after restart", {16'h0, pin_out}, 32'h1234);
        // R11 unmapped
        rd(3'd6, v); check("R11 unmapped read", v, 0);
        idle(2);
        finish_run();
    end
endmodule